// File: doc/BRIEF.md
# Event Flag Latch and Interrupt Gate

This block sits behind a PWM event selector. It receives single-cycle strobes for three events: one interrupt request and two ADC start-of-conversion channels, called A and B. For each event it drives a one-cycle pulse output and latches a sticky status flag. Software reads the flags through a small synchronous register bus and clears them with write-one-to-clear writes.

The two conversion channels pulse on every strobe, whatever their flags hold. The interrupt channel is gated by its flag. After one interrupt pulse, no further interrupt pulse leaves the block until software clears the flag. While the flag is set, one extra interrupt strobe is held as pending and any later strobes are dropped. Clearing the flag while an interrupt is pending releases that interrupt in the next cycle and sets the flag again.

No data stream passes through the block, so it has no valid/ready handshake. All pins are plain control and status signals. Register reads take one cycle. The read data presented in a cycle reflects the address sampled at the previous clock edge.

Top module: `evt_flag_gate`

## Requirements
- R1: After reset all three flags are 0, no interrupt is pending, and all pulse outputs and the read data are 0.
- R2: The flag register at address 0 holds the interrupt flag in bit 0, the conversion-A flag in bit 2 and the conversion-B flag in bit 3. Bit 1 and bits 15..4 read as 0.
- R3: A strobe on a conversion channel produces a pulse on its output in the cycle after the strobe and sets its flag. Later strobes still pulse the output while the flag is set.
- R4: An interrupt strobe that arrives while the interrupt flag is clear produces exactly one interrupt pulse in the next cycle and sets the interrupt flag.
- R5: While the interrupt flag is set, no interrupt pulse is emitted. The first strobe in that state becomes pending, and further strobes are dropped.
- R6: A clear of the interrupt flag while an interrupt is pending emits one interrupt pulse in the cycle after the clear write. The flag is set again and the pending state is emptied, so a second clear produces no pulse.
- R7: The clear register at address 1 uses the same bit positions as the flag register. Writing 1 to a bit clears the matching flag, writing 0 has no effect, and a read of this address returns 0.
- R8: When a strobe and a clear of the same flag fall in the same cycle, the strobe wins and the flag stays set. For the interrupt flag, such a strobe yields a pulse only if no interrupt is pending; otherwise the pending interrupt is released and the strobe is dropped.
- R9: Every pulse output is exactly one clock cycle wide per strobe or release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_evt | input | 1 | Interrupt event strobe |
| soca_evt | input | 1 | Conversion-A event strobe |
| socb_evt | input | 1 | Conversion-B event strobe |
| reg_addr | input | 4 | Register address (0 flags, 1 clear) |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| int_pulse | output | 1 | Interrupt pulse output |
| soca_pulse | output | 1 | Conversion-A trigger pulse |
| socb_pulse | output | 1 | Conversion-B trigger pulse |

## Verification
The critical coincidence is an event strobe arriving in the same cycle as a software clear of the same flag. The interrupt channel adds a second one: a clear that releases a pending interrupt while a fresh strobe arrives. The bench provokes both by placing a strobe and a clear write in one vector, first with nothing pending and then with an interrupt held. It judges each case by the pulse seen in the next cycle and by a later flag read. The conversion channels are driven the same way, and the bench confirms through the flag register that their flags stay set.

// File: rtl/evt_gate_pkg.sv
package evt_gate_pkg;
  localparam int REG_W    = 16;
  localparam int BIT_INT  = 0;
  localparam int BIT_SOCA = 2;
  localparam int BIT_SOCB = 3;
  localparam int NUM_SOC  = 2;
endpackage

// File: rtl/evt_soc_chan.sv
module evt_soc_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic pulse,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pulse <= evt;
      // a strobe in the same cycle as a clear keeps the flag set
      flag  <= evt | (flag & ~clr);
    end
  end
endmodule

// File: rtl/evt_int_gate.sv
module evt_int_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic pulse,
  output logic flag,
  output logic pending
);
  logic fire_d, flag_d, pend_d;

  always_comb begin
    fire_d = 1'b0;
    flag_d = flag & ~clr;
    pend_d = pending;
    if (clr && pending) begin
      // release held interrupt; coincident strobe is dropped
      fire_d = 1'b1;
      flag_d = 1'b1;
      pend_d = 1'b0;
    end else if (evt && (!flag || clr)) begin
      fire_d = 1'b1;
      flag_d = 1'b1;
    end else if (evt) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse   <= 1'b0;
      flag    <= 1'b0;
      pending <= 1'b0;
    end else begin
      pulse   <= fire_d;
      flag    <= flag_d;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/evt_regif.sv
module evt_regif
  import evt_gate_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 0,
  parameter int CLR_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              flag_int,
  input  logic              flag_soca,
  input  logic              flag_socb,
  output logic              clr_int,
  output logic              clr_soca,
  output logic              clr_socb,
  output logic [REG_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);

  logic             clr_hit;
  logic [REG_W-1:0] flag_word;

  assign clr_hit  = wr && (addr == A_CLR);
  assign clr_int  = clr_hit & wdata[BIT_INT];
  assign clr_soca = clr_hit & wdata[BIT_SOCA];
  assign clr_socb = clr_hit & wdata[BIT_SOCB];

  always_comb begin
    flag_word           = '0;
    flag_word[BIT_INT]  = flag_int;
    flag_word[BIT_SOCA] = flag_soca;
    flag_word[BIT_SOCB] = flag_socb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (addr == A_FLAG) rdata <= flag_word;
    else rdata <= '0;
  end
endmodule

// File: rtl/evt_flag_gate.sv
module evt_flag_gate
  import evt_gate_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 0,
  parameter int CLR_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_evt,
  input  logic              soca_evt,
  input  logic              socb_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              int_pulse,
  output logic              soca_pulse,
  output logic              socb_pulse
);
  logic               flag_int, int_pend, clr_int;
  logic [NUM_SOC-1:0] soc_evt, soc_clr, soc_pulse, soc_flag;

  assign soc_evt    = {socb_evt, soca_evt};
  assign soca_pulse = soc_pulse[0];
  assign socb_pulse = soc_pulse[1];

  evt_regif #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .CLR_ADDR(CLR_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .flag_int(flag_int), .flag_soca(soc_flag[0]), .flag_socb(soc_flag[1]),
    .clr_int(clr_int), .clr_soca(soc_clr[0]), .clr_socb(soc_clr[1]),
    .rdata(reg_rdata)
  );

  evt_int_gate u_int (
    .clk(clk), .rst_n(rst_n), .evt(int_evt), .clr(clr_int),
    .pulse(int_pulse), .flag(flag_int), .pending(int_pend)
  );

  for (genvar g = 0; g < NUM_SOC; g++) begin : g_soc
    evt_soc_chan u_chan (
      .clk(clk), .rst_n(rst_n), .evt(soc_evt[g]), .clr(soc_clr[g]),
      .pulse(soc_pulse[g]), .flag(soc_flag[g])
    );
  end
endmodule

// File: rtl/evt_flag_gate_chk.sv
module evt_flag_gate_chk #(
  parameter int ADDR_W   = 4,
  parameter int CLR_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_evt,
  input logic              soca_evt,
  input logic              socb_evt,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [15:0]       reg_wdata,
  input logic [15:0]       reg_rdata,
  input logic              int_pulse,
  input logic              soca_pulse,
  input logic              socb_pulse,
  input logic              flag_int,
  input logic              int_pend,
  input logic [1:0]        soc_flag
);
  logic clr_i;
  assign clr_i = reg_wr && (reg_addr == ADDR_W'(CLR_ADDR)) && reg_wdata[0];

  // R5: flag set and not cleared -> no interrupt pulse next cycle
  assert_int_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_int && !clr_i) |=> !int_pulse);
  // R4: any interrupt pulse comes with the flag set
  assert_pulse_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_pulse |-> flag_int);
  // R3: conversion strobes always pulse, and set the flag
  assert_soca_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soca_evt |=> (soca_pulse && soc_flag[0]));
  assert_socb_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    socb_evt |=> (socb_pulse && soc_flag[1]));
  // R8: strobe with clear keeps the flag set
  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_evt |=> flag_int);
  // R6: release empties the pending state
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && int_pend) |=> (int_pulse && !int_pend));
  // R7: clear address reads zero
  assert_clr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CLR_ADDR)) |=> (reg_rdata == 16'h0000));
  // R2: reserved bits read zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1] == 1'b0) && (reg_rdata[15:4] == 12'h000));
endmodule

bind evt_flag_gate evt_flag_gate_chk #(.ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_evt(int_evt), .soca_evt(soca_evt), .socb_evt(socb_evt),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .int_pulse(int_pulse), .soca_pulse(soca_pulse), .socb_pulse(socb_pulse),
  .flag_int(flag_int), .int_pend(int_pend), .soc_flag(soc_flag)
);

// File: tb/evt_flag_gate_test.sv
module evt_flag_gate_test;
  localparam int CLK_P = 10;
  localparam int NV    = 16;
  // stimulus {int,a,b,clr_int,clr_a,clr_b} expected pulses {int,a,b}
  localparam logic [8:0] VEC [NV] = '{
    9'b100_000_100, // R4 first interrupt
    9'b000_000_000,
    9'b100_000_000, // R5 becomes pending
    9'b100_000_000, // R5 dropped
    9'b010_000_010, // R3
    9'b010_000_010, // R3 pulses while flag set
    9'b001_000_001, // R3 channel B
    9'b000_100_100, // R6 release pending
    9'b000_100_000, // R6 nothing pending now
    9'b100_100_100, // R8 strobe+clear, nothing pending
    9'b100_000_000, // R5 pending again
    9'b100_100_100, // R8 strobe+clear with pending: release, strobe dropped
    9'b000_100_000, // R8 nothing was re-held
    9'b111_000_111, // R9 all channels
    9'b000_111_000, // R7 clear all
    9'b010_010_010  // R8 conversion strobe wins over clear
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic int_evt = 0, soca_evt = 0, socb_evt = 0, reg_wr = 0;
  logic [3:0] reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'h0, reg_rdata;
  logic int_pulse, soca_pulse, socb_pulse;
  int checks = 0, fails = 0;
  bit done = 0;

  evt_flag_gate uut (
    .clk(clk), .rst_n(rst_n), .int_evt(int_evt), .soca_evt(soca_evt), .socb_evt(socb_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_pulse(int_pulse), .soca_pulse(soca_pulse), .socb_pulse(socb_pulse)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic i, a, b, input logic [15:0] clr_bits, input bit do_clr);
    @(negedge clk);
    int_evt = i; soca_evt = a; socb_evt = b;
    reg_wr = do_clr; reg_addr = do_clr ? 4'd1 : 4'd0; reg_wdata = clr_bits;
    @(posedge clk); #1;
    @(negedge clk);
    int_evt = 0; soca_evt = 0; socb_evt = 0; reg_wr = 0; reg_addr = 4'd0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_wr = 0;
    @(posedge clk); #1;
    v = reg_rdata;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    #(CLK_P * 3);
    check("R1 pulses", {13'd0, int_pulse, soca_pulse, socb_pulse}, 16'h0);
    check("R1 rdata", reg_rdata, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(4'd0, v); check("R1 flags", v, 16'h0);

    for (int k = 0; k < NV; k++) begin
      logic [15:0] cb;
      cb = 16'h0;
      cb[0] = VEC[k][5]; cb[2] = VEC[k][4]; cb[3] = VEC[k][3];
      @(negedge clk);
      int_evt = VEC[k][8]; soca_evt = VEC[k][7]; socb_evt = VEC[k][6];
      reg_wr = |VEC[k][5:3]; reg_addr = (|VEC[k][5:3]) ? 4'd1 : 4'd0; reg_wdata = cb;
      @(posedge clk); #1;
      check($sformatf("R3/R4/R5/R6/R8 vec%0d", k),
            {13'd0, int_pulse, soca_pulse, socb_pulse}, {13'd0, VEC[k][2:0]});
    end
    @(negedge clk);
    int_evt = 0; soca_evt = 0; socb_evt = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    @(posedge clk); #1;
    check("R9 pulse width", {13'd0, int_pulse, soca_pulse, socb_pulse}, 16'h0);

    rd(4'd0, v); check("R8 soca flag kept", v, 16'h0004);
    step(0, 0, 0, 16'h0000, 1);
    rd(4'd0, v); check("R7 zero write no effect", v, 16'h0004);
    rd(4'd1, v); check("R7 clear reads zero", v, 16'h0);
    step(1, 0, 1, 16'h0, 0);
    rd(4'd0, v); check("R2 layout", v, 16'h000D);
    step(0, 0, 0, 16'h0008, 1);
    rd(4'd0, v); check("R7 clear B only", v, 16'h0005);
    step(0, 0, 0, 16'hFFFF, 1);
    rd(4'd0, v); check("R7 clear all", v, 16'h0000);

    // interrupt pending, release, flag re-set
    step(1, 0, 0, 16'h0, 0);
    step(1, 0, 0, 16'h0, 0);
    step(0, 0, 0, 16'h0001, 1);
    rd(4'd0, v); check("R6 flag set after release", v, 16'h0001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule